// File: doc/BRIEF.md
# Incrementing Skid-Buffered Pipeline Stage

This block is one stage of a streaming datapath. Words arrive on an upstream port guarded by a valid/ready handshake, are incremented by one, and leave through a registered downstream port with its own valid/ready handshake. The result is held in an output register, so the stage breaks the combinational path on both data and valid.

A second, one-word holding register sits next to the output register. It catches a word that arrives while the downstream side is stalled. Because of it, the upstream ready signal comes straight from a flop and can stay high through the first cycle of a downstream stall. No word is lost or duplicated, and held words drain in arrival order once the stall ends. Stages of this kind can be chained: the downstream port of one connects directly to the upstream port of the next.

Top module: `pipe_incr_stage`

## Requirements
- R1: A synchronous active-high reset empties the stage. During reset and after it, `dn_valid` is 0 and `up_ready` is 1, even if reset is applied while words are held.
- R2: A word accepted into an empty stage appears on the downstream port with `dn_valid` high one clock after the accepting edge, and not in the same cycle.
- R3: Each delivered word equals its accepted word plus one, modulo 2^WIDTH, so 16'hFFFF becomes 16'h0000.
- R4: Under arbitrary patterns of upstream sending and downstream stalling, every accepted word is delivered exactly once and in acceptance order.
- R5: While `dn_valid` is high and `dn_ready` is low, `dn_valid` stays high and `dn_data` stays unchanged on the next cycle.
- R6: `up_ready` stays high on the first stall cycle and accepts one extra word. It goes low only when both the output register and the holding register are full, and `dn_valid` is then always high.
- R7: After a stall clears, `dn_valid` stays high until every held word has been delivered, even when `up_valid` is already low.
- R8: When the output register empties while the holding register is full, the held word is delivered next, before any newer upstream word.
- R9: A cycle with `up_valid` low, or with `up_ready` low, accepts nothing: the data on `up_data` in that cycle never appears downstream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| up_valid | input | 1 | Upstream word present |
| up_ready | output | 1 | Stage can take an upstream word this cycle |
| up_data | input | WIDTH | Upstream word |
| dn_valid | output | 1 | Downstream word present |
| dn_ready | input | 1 | Downstream consumer takes the word this cycle |
| dn_data | output | WIDTH | Downstream word (accepted word plus one) |

## Verification
The stage can hold zero, one or two words. A wrong occupancy shows at the ports within one to two cycles. If a word is dropped, the next delivered value skips one. If a word is duplicated, a value repeats. If `up_ready` is wrongly low, the bench sees it together with `dn_valid` low. If the holding register is wrong, the word delivered right after a stall clears is out of order. The directed table places every such deviation at a precise cycle. The randomized stream then checks that one hundred consecutive words arrive incremented, complete and in order.

// File: rtl/pipe_incr_pkg.sv
package pipe_incr_pkg;

    // Occupancy of the stage: nothing, output register only, output + hold register
    typedef enum logic [1:0] {
        OCC_EMPTY = 2'd0,
        OCC_ONE   = 2'd1,
        OCC_TWO   = 2'd2
    } occ_e;

    // Control decision for one cycle
    typedef struct packed {
        occ_e nxt;
        logic load_out;
        logic out_from_hold;
        logic load_hold;
    } step_t;

    function automatic step_t occ_step(input occ_e cur, input logic take, input logic give);
        step_t s;
        s.nxt           = cur;
        s.load_out      = 1'b0;
        s.out_from_hold = 1'b0;
        s.load_hold     = 1'b0;
        case (cur)
            OCC_ONE: begin
                if (give) begin
                    s.load_out = take;
                    s.nxt      = take ? OCC_ONE : OCC_EMPTY;
                end else if (take) begin
                    s.load_hold = 1'b1;
                    s.nxt       = OCC_TWO;
                end
            end
            OCC_TWO: begin
                if (give) begin
                    s.load_out      = 1'b1;
                    s.out_from_hold = 1'b1;
                    s.nxt           = OCC_ONE;
                end
            end
            default: begin
                if (take) begin
                    s.load_out = 1'b1;
                    s.nxt      = OCC_ONE;
                end else begin
                    s.nxt = OCC_EMPTY;
                end
            end
        endcase
        return s;
    endfunction

endpackage

// File: rtl/pipe_incr_op.sv
module pipe_incr_op #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] operand,
    output logic [WIDTH-1:0] result
);
    localparam logic [WIDTH-1:0] STEP = WIDTH'(1);

    // Wraps modulo 2^WIDTH by truncation
    assign result = operand + STEP;
endmodule

// File: rtl/pipe_incr_datareg.sv
module pipe_incr_datareg #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end
endmodule

// File: rtl/pipe_incr_ctrl.sv
module pipe_incr_ctrl
    import pipe_incr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic up_valid,
    input  logic dn_ready,
    output logic up_ready,
    output logic dn_valid,
    output logic load_out,
    output logic out_from_hold,
    output logic load_hold
);
    occ_e  occ_q;
    step_t step;
    logic  take;
    logic  give;

    assign up_ready = (occ_q != OCC_TWO);
    assign dn_valid = (occ_q != OCC_EMPTY);
    assign take     = up_valid && up_ready;
    assign give     = dn_valid && dn_ready;

    always_comb begin
        step = occ_step(occ_q, take, give);
    end

    assign load_out      = step.load_out;
    assign out_from_hold = step.out_from_hold;
    assign load_hold     = step.load_hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            occ_q <= OCC_EMPTY;
        end else begin
            occ_q <= step.nxt;
        end
    end

    // R6: a word taken during the first stall cycle fills the stage, dropping ready
    a_r6_fill_drops_ready: assert property (@(posedge clk) disable iff (rst)
        (dn_valid && up_ready && !dn_ready && up_valid) |=> !up_ready);

    // R6: ready low only with a word on the output
    a_r6_ready_low_full: assert property (@(posedge clk) disable iff (rst)
        !up_ready |-> dn_valid);

    // R9: with no word offered and none present, the output stays empty
    a_r9_idle_stays_empty: assert property (@(posedge clk) disable iff (rst)
        (!up_valid && !dn_valid) |=> !dn_valid);

    // R7: held words keep valid high after the stall clears
    a_r7_drain: assert property (@(posedge clk) disable iff (rst)
        (!up_ready && dn_ready) |=> dn_valid);
endmodule

// File: rtl/pipe_incr_stage.sv
module pipe_incr_stage
    import pipe_incr_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             up_valid,
    output logic             up_ready,
    input  logic [WIDTH-1:0] up_data,
    output logic             dn_valid,
    input  logic             dn_ready,
    output logic [WIDTH-1:0] dn_data
);
    logic             load_out;
    logic             out_from_hold;
    logic             load_hold;
    logic [WIDTH-1:0] incr_w;
    logic [WIDTH-1:0] hold_q;
    logic [WIDTH-1:0] out_d;

    pipe_incr_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .up_valid      (up_valid),
        .dn_ready      (dn_ready),
        .up_ready      (up_ready),
        .dn_valid      (dn_valid),
        .load_out      (load_out),
        .out_from_hold (out_from_hold),
        .load_hold     (load_hold)
    );

    pipe_incr_op #(.WIDTH(WIDTH)) u_op (
        .operand (up_data),
        .result  (incr_w)
    );

    assign out_d = out_from_hold ? hold_q : incr_w;

    pipe_incr_datareg #(.WIDTH(WIDTH)) u_hold (
        .clk  (clk),
        .rst  (rst),
        .load (load_hold),
        .d    (incr_w),
        .q    (hold_q)
    );

    pipe_incr_datareg #(.WIDTH(WIDTH)) u_out (
        .clk  (clk),
        .rst  (rst),
        .load (load_out),
        .d    (out_d),
        .q    (dn_data)
    );

    // R5: a stalled output word is held unchanged
    a_r5_stall_hold: assert property (@(posedge clk) disable iff (rst)
        (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_data)));

    // R2: word taken into an empty stage is valid one clock later
    a_r2_latency: assert property (@(posedge clk) disable iff (rst)
        (up_valid && up_ready && !dn_valid) |=> dn_valid);

    // R3: that word is the input plus one, wrapping
    a_r3_increment: assert property (@(posedge clk) disable iff (rst)
        (up_valid && up_ready && !dn_valid) |=> (dn_data == $past(up_data) + WIDTH'(1)));

    // R8: on drain from a full stage the held word is delivered next
    a_r8_hold_first: assert property (@(posedge clk) disable iff (rst)
        (!up_ready && dn_ready) |=> (dn_data == $past(hold_q)));
endmodule

// File: tb/pipe_incr_stage_tb.sv
`timescale 1ns/1ps
module pipe_incr_stage_tb_top;
    localparam int    W        = 16;
    localparam time   CLK_P    = 8ns;
    localparam int    N_ROWS   = 12;
    localparam int    N_RAND   = 100;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         up_valid = 1'b0;
    logic         up_ready;
    logic [W-1:0] up_data = '0;
    logic         dn_valid;
    logic         dn_ready = 1'b0;
    logic [W-1:0] dn_data;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    pipe_incr_stage #(.WIDTH(W)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .up_valid (up_valid),
        .up_ready (up_ready),
        .up_data  (up_data),
        .dn_valid (dn_valid),
        .dn_ready (dn_ready),
        .dn_data  (dn_data)
    );

    // Row: {up_valid, up_data, dn_ready, exp dn_valid, exp dn_data, exp up_ready}
    // Expected values are the outputs after the edge that follows the drive.
    localparam logic [35:0] TBL [N_ROWS] = '{
        {1'b1, 16'h0005, 1'b1, 1'b1, 16'h0006, 1'b1},  // R2 R3 first word
        {1'b1, 16'h0007, 1'b1, 1'b1, 16'h0008, 1'b1},  // R4 back-to-back
        {1'b1, 16'h0002, 1'b0, 1'b1, 16'h0008, 1'b0},  // R6 stall: taken into hold
        {1'b1, 16'h0009, 1'b0, 1'b1, 16'h0008, 1'b0},  // R9 ready low: refused
        {1'b0, 16'h000C, 1'b1, 1'b1, 16'h0003, 1'b1},  // R8 R7 held word next
        {1'b0, 16'h0020, 1'b1, 1'b0, 16'h0000, 1'b1},  // R7 drained
        {1'b0, 16'h002C, 1'b1, 1'b0, 16'h0000, 1'b1},  // R9 idle
        {1'b1, 16'hFFFF, 1'b0, 1'b1, 16'h0000, 1'b1},  // R3 wrap
        {1'b1, 16'h1234, 1'b0, 1'b1, 16'h0000, 1'b0},  // R6 fill
        {1'b1, 16'h4000, 1'b1, 1'b1, 16'h1235, 1'b1},  // R8 R9 held first, new refused
        {1'b1, 16'h4000, 1'b1, 1'b1, 16'h4001, 1'b1},  // R4 resend taken
        {1'b0, 16'h0000, 1'b1, 1'b0, 16'h0000, 1'b1}   // R7 empty
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_P * 50000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // Reset state (R1)
        repeat (3) @(posedge clk);
        #2;
        chk("R1 dn_valid in reset", 32'(dn_valid), 32'd0);
        chk("R1 up_ready in reset", 32'(up_ready), 32'd1);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #2;
        chk("R1 dn_valid after reset", 32'(dn_valid), 32'd0);

        // Directed table
        for (int i = 0; i < N_ROWS; i++) begin
            @(negedge clk);
            up_valid = TBL[i][35];
            up_data  = TBL[i][34:19];
            dn_ready = TBL[i][18];
            @(posedge clk);
            #2;
            chk($sformatf("R5 row %0d dn_valid", i), 32'(dn_valid), 32'(TBL[i][17]));
            if (TBL[i][17])
                chk($sformatf("R3 row %0d dn_data", i), 32'(dn_data), 32'(TBL[i][16:1]));
            chk($sformatf("R6 row %0d up_ready", i), 32'(up_ready), 32'(TBL[i][0]));
        end

        // Reset while the stage is full (R1)
        @(negedge clk);
        up_valid = 1'b1; up_data = 16'h0100; dn_ready = 1'b0;
        @(negedge clk);
        up_data = 16'h0200;
        @(negedge clk);
        chk("R6 full before reset", 32'(up_ready), 32'd0);
        up_valid = 1'b0;
        rst = 1'b1;
        @(posedge clk);
        #2;
        chk("R1 reset clears valid", 32'(dn_valid), 32'd0);
        chk("R1 reset raises ready", 32'(up_ready), 32'd1);
        @(negedge clk);
        rst = 1'b0;
        up_valid = 1'b0; up_data = 16'hBEEF; dn_ready = 1'b1;
        @(posedge clk);
        #2;
        chk("R9 no word after reset", 32'(dn_valid), 32'd0);

        // Randomized stream (R4)
        begin
            int sent = 0;
            int got = 0;
            int cyc = 0;
            logic [W-1:0] expw;
            while (got < N_RAND && cyc < 20000) begin
                @(negedge clk);
                cyc++;
                dn_ready = ($urandom_range(0, 3) != 0);
                if (sent < N_RAND && $urandom_range(0, 2) != 0) begin
                    up_valid = 1'b1;
                    up_data  = W'(sent * 16'd997 + 16'hFFF0);
                end else begin
                    up_valid = 1'b0;
                    up_data  = W'($urandom);
                end
                #1;
                if (!up_ready)
                    chk("R6 ready low implies valid", 32'(dn_valid), 32'd1);
                if (up_valid && up_ready)
                    sent++;
                if (dn_valid && dn_ready) begin
                    expw = W'(got * 16'd997 + 16'hFFF0) + W'(1);
                    chk($sformatf("R4 word %0d", got), 32'(dn_data), 32'(expw));
                    got++;
                end
            end
            chk("R4 all words delivered", 32'(got), 32'(N_RAND));
            @(negedge clk);
            up_valid = 1'b0;
            dn_ready = 1'b1;
            @(posedge clk);
            #2;
            chk("R4 no extra word", 32'(dn_valid), 32'd0);
        end

        finish_run();
    end
endmodule